// File: doc/BRIEF.md
# Programmable Down-Counting Interrupt Timer

This block is a 32-bit countdown timer sitting on a simple register bus. Software sets a divide code, a control word and a start value. Writing the start value launches a countdown. The counter then decreases by one on every prescaler tick. When it reaches zero, the block emits a one-cycle interrupt request that carries a programmable vector. Software can read the remaining count at any moment. The elapsed tick count is therefore the start value minus the value read.

The counter is driven by a small state machine with four states:
- `ST_IDLE`: stopped after reset or after a zero start value.
- `ST_COUNT`: decrementing on each tick.
- `ST_WRAP`: the count sits at zero, waiting one tick before a periodic reload.
- `ST_DONE`: a one-shot countdown has expired and the count is held at zero.

The state machine moves between them as follows:
- Loading a nonzero value moves any state to `ST_COUNT`; loading zero moves any state to `ST_IDLE`.
- On the tick that takes the count from one to zero, `ST_COUNT` goes to `ST_WRAP` in periodic mode and to `ST_DONE` in one-shot mode.
- On its next tick, `ST_WRAP` reloads and returns to `ST_COUNT`. If the mode has been switched to one-shot by then, it goes to `ST_DONE` instead.

The prescaler is a free-running counter that is cleared whenever a countdown starts. Its tick period is a power of two chosen by the divide code.

Top module: `countdown_irq_timer`

## Requirements
- R1: After reset the current count reads 0, the start-value register reads 0, the divide register reads 0, the control word reads 0x0001_0000 (masked, one-shot, vector 0) and no request is raised.
- R2: The divisor comes from divide-register bits {3,1,0}, which select 2, 4, 8, 16, 32, 64, 128 and 1 for the values 000 to 111. Bit 2 is stored but has no effect on the divisor.
- R3: A write to the start-value register (offset 0x380) loads the counter and clears the prescaler. The current-count register (offset 0x390) returns the remaining value in the cycle after the write.
- R4: With divisor D and start value N, the count decreases by exactly one every D clocks. It reaches zero, and the request appears, N*D clock edges after the write edge.
- R5: In one-shot mode (control bit 17 = 0) the request fires exactly once and the count then stays at zero.
- R6: In periodic mode (control bit 17 = 1) the count reloads the start value on the tick after it reaches zero, so requests repeat every (N+1)*D clocks.
- R7: When the mask (control bit 16) is set, no request is raised, but the count keeps decreasing.
- R8: Writing a start value of 0 stops the timer with a count of 0, and no request follows.
- R9: The request `irq_valid_o` is high for a single cycle, and `irq_vector_o` then equals control bits [7:0].
- R10: The control word is at offset 0x320 and the divide register at offset 0x3E0. Unused control bits read 0, divide bits [31:4] read 0, and unmapped offsets read 0 and ignore writes.
- R11: Rewriting the start value during a countdown restarts it from the new value, and the abandoned countdown raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_vector_o | output | 8 | Vector delivered with the request |

## Verification
The assertions assume the following about the inputs:
- The divide code and the mode bit are changed only while the timer is idle, or together with a fresh start-value write. The tick-spacing and wrap properties rely on this.
- The write strobe is a clean one-cycle pulse per access.

The directed stimulus respects these assumptions. Every configuration write happens before the start-value write, every scenario ends by writing a zero start value, and bus inputs change only on the falling clock edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W    = 32;
    localparam int VEC_W     = 8;
    localparam int SHIFT_W   = 3;
    localparam int MAX_SHIFT = 7;
    localparam int PRE_W     = MAX_SHIFT;

    localparam logic [11:0] OFF_CTRL  = 12'h320;
    localparam logic [11:0] OFF_START = 12'h380;
    localparam logic [11:0] OFF_NOW   = 12'h390;
    localparam logic [11:0] OFF_DIV   = 12'h3E0;

    localparam int BIT_PERIODIC = 17;
    localparam int BIT_MASK     = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_WRAP,
        ST_DONE
    } tmr_state_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } tmr_ctl_t;

    // Divide code bits {3,1,0} plus one, modulo eight, gives log2 of the divisor.
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
        logic [SHIFT_W-1:0] sel;
        sel = {code[3], code[1], code[0]};
        return sel + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               tick_o
);

    logic [PRE_W-1:0] div_cnt_q;
    logic [PRE_W-1:0] div_mask;

    assign div_mask = ~({PRE_W{1'b1}} << shift_i);
    assign tick_o   = ((div_cnt_q & div_mask) == div_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
        end else if (restart_i) begin
            div_cnt_q <= '0;
        end else begin
            div_cnt_q <= div_cnt_q + PRE_W'(1);
        end
    end

    // R2: for a divisor above one, two ticks are never adjacent
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && shift_i != '0 && !restart_i) |=> (!tick_o || shift_i != $past(shift_i)));

    // R3: a restart clears the prescaler phase
    a_r3_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (tick_o == (shift_i == '0)));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  now_count_i,
    output logic [DATA_W-1:0] rdata_o,
    output tmr_ctl_t          ctl_o,
    output logic [3:0]        div_code_o,
    output logic [CNT_W-1:0]  start_o,
    output logic              load_o
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
    localparam logic [ADDR_W-1:0] A_NOW   = ADDR_W'(OFF_NOW);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFF_DIV);

    tmr_ctl_t          ctl_q;
    logic [3:0]        div_q;
    logic [CNT_W-1:0]  start_q;
    logic [DATA_W-1:0] now_ext;
    logic [DATA_W-1:0] start_ext;
    logic [DATA_W-1:0] ctl_ext;

    logic sel_ctrl, sel_start, sel_div;
    assign sel_ctrl  = wr_i && (addr_i == A_CTRL);
    assign sel_start = wr_i && (addr_i == A_START);
    assign sel_div   = wr_i && (addr_i == A_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
            div_q   <= '0;
            start_q <= '0;
        end else begin
            if (sel_ctrl) begin
                ctl_q.periodic <= wdata_i[BIT_PERIODIC];
                ctl_q.mask     <= wdata_i[BIT_MASK];
                ctl_q.vector   <= wdata_i[VEC_W-1:0];
            end
            if (sel_div) begin
                div_q <= wdata_i[3:0];
            end
            if (sel_start) begin
                start_q <= wdata_i[CNT_W-1:0];
            end
        end
    end

    generate
        if (CNT_W < DATA_W) begin : g_narrow
            assign now_ext   = {{(DATA_W-CNT_W){1'b0}}, now_count_i};
            assign start_ext = {{(DATA_W-CNT_W){1'b0}}, start_q};
        end else begin : g_full
            assign now_ext   = now_count_i;
            assign start_ext = start_q;
        end
    endgenerate

    always_comb begin
        ctl_ext               = '0;
        ctl_ext[VEC_W-1:0]    = ctl_q.vector;
        ctl_ext[BIT_MASK]     = ctl_q.mask;
        ctl_ext[BIT_PERIODIC] = ctl_q.periodic;
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rdata_o = ctl_ext;
            A_START: rdata_o = start_ext;
            A_NOW:   rdata_o = now_ext;
            A_DIV:   rdata_o = {{(DATA_W-4){1'b0}}, div_q};
            default: rdata_o = '0;
        endcase
    end

    assign ctl_o      = ctl_q;
    assign div_code_o = div_q;
    assign start_o    = start_q;
    assign load_o     = sel_start;

    // R10: the start register changes only through a write at its own offset
    a_r10_start_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_start |=> $stable(start_q));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             tick_i,
    input  tmr_ctl_t         ctl_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_valid_o,
    output logic [VEC_W-1:0] irq_vector_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             expire;

    assign expire = !load_i && (state_q == ST_COUNT) && tick_i && (count_q == ONE);

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (load_i) begin
            count_d = load_val_i;
            state_d = (load_val_i == '0) ? ST_IDLE : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    count_d = '0;
                end
                ST_COUNT: begin
                    if (tick_i) begin
                        count_d = count_q - ONE;
                        if (count_q == ONE) begin
                            state_d = ctl_i.periodic ? ST_WRAP : ST_DONE;
                        end
                    end
                end
                ST_WRAP: begin
                    if (tick_i) begin
                        if (ctl_i.periodic) begin
                            count_d = reload_val_i;
                            state_d = ST_COUNT;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    count_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid_o  <= 1'b0;
            irq_vector_o <= '0;
        end else begin
            irq_valid_o <= expire && !ctl_i.mask;
            if (expire && !ctl_i.mask) begin
                irq_vector_o <= ctl_i.vector;
            end
        end
    end

    assign count_o = count_q;

    // R9: the request never lasts two cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |=> !irq_valid_o);

    // R7: a request only follows an unmasked control word
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> !$past(ctl_i.mask));

    // R4: each tick while counting takes exactly one off the count
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick_i && !load_i) |=> (count_q == $past(count_q) - ONE));

    // R4: the counting state never holds a zero count
    a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (count_q != '0));

    // R5: an expired one-shot stays at zero
    a_r5_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (count_q == '0));

    // R6: the wrap tick restores the start value
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP && tick_i && ctl_i.periodic && !load_i)
            |=> (count_q == $past(reload_val_i)));

    // R8: a zero start value parks the counter
    a_r8_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (state_q == ST_IDLE && count_q == '0));

endmodule

// File: rtl/countdown_irq_timer.sv
module countdown_irq_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_valid_o,
    output logic [7:0]        irq_vector_o
);

    tmr_ctl_t           ctl;
    logic [3:0]         div_code;
    logic [CNT_W-1:0]   start_val;
    logic [CNT_W-1:0]   now_count;
    logic               load;
    logic               tick;
    logic [SHIFT_W-1:0] shift;

    assign shift = div_shift(div_code);

    tmr_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .now_count_i (now_count),
        .rdata_o     (bus_rdata_o),
        .ctl_o       (ctl),
        .div_code_o  (div_code),
        .start_o     (start_val),
        .load_o      (load)
    );

    tmr_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .shift_i   (shift),
        .tick_o    (tick)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .load_val_i   (bus_wdata_i[CNT_W-1:0]),
        .reload_val_i (start_val),
        .tick_i       (tick),
        .ctl_i        (ctl),
        .count_o      (now_count),
        .irq_valid_o  (irq_valid_o),
        .irq_vector_o (irq_vector_o)
    );

endmodule

// File: tb/test_countdown_irq_timer.sv
module test_countdown_irq_timer;

    localparam logic [11:0] A_CTRL  = 12'h320;
    localparam logic [11:0] A_START = 12'h380;
    localparam logic [11:0] A_NOW   = 12'h390;
    localparam logic [11:0] A_DIV   = 12'h3E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    int unsigned wr_cyc = 0;
    int unsigned pulse_total = 0;
    int unsigned dbl_total = 0;
    int unsigned pulse_cyc [0:63];
    logic [7:0]  pulse_vec [0:63];
    logic        prev_valid = 1'b0;

    always #5 clk = ~clk;

    countdown_irq_timer i_countdown_irq_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .irq_valid_o  (irq_valid),
        .irq_vector_o (irq_vector)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (irq_valid) begin
            pulse_cyc[pulse_total % 64] = cyc;
            pulse_vec[pulse_total % 64] = irq_vector;
            pulse_total = pulse_total + 1;
            if (prev_valid) dbl_total = dbl_total + 1;
        end
        prev_valid = irq_valid;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int unsigned target);
        do @(negedge clk); while (cyc < target);
    endtask

    function automatic logic [31:0] ctl_word(input logic per, input logic msk, input logic [7:0] v);
        return {14'b0, per, msk, 8'b0, v};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        rd(A_NOW, d);   chk("R1 count", d, 0);
        rd(A_START, d); chk("R1 start", d, 0);
        rd(A_DIV, d);   chk("R1 div", d, 0);
        rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0001_0000);
        chk("R1 irq", {31'b0, irq_valid}, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        int unsigned base, w;
        wr(A_CTRL, ctl_word(1'b0, 1'b0, 8'h41));
        wr(A_DIV, 32'hB);
        base = pulse_total;
        wr(A_START, 5);
        w = wr_cyc;
        @(negedge clk);
        rd(A_NOW, d); chk("R3 loaded", d, 5);
        wait_to(w + 2);
        rd(A_NOW, d); chk("R3 remaining", d, 3);
        wait_to(w + 40);
        chk("R5 one pulse", pulse_total - base, 1);
        chk("R4 expiry edge", pulse_cyc[base % 64], w + 5);
        chk("R9 vector", {24'b0, pulse_vec[base % 64]}, 32'h41);
        rd(A_NOW, d); chk("R5 stays zero", d, 0);
        wr(A_START, 0);
    endtask

    task automatic t_div_one(input logic [3:0] code, input int unsigned dv);
        int unsigned base, w;
        wr(A_DIV, {28'b0, code});
        base = pulse_total;
        wr(A_START, 3);
        w = wr_cyc;
        wait_to(w + 3 * dv + 3);
        chk("R2 pulses", pulse_total - base, 1);
        chk("R2 divisor timing", pulse_cyc[base % 64], w + 3 * dv);
        wr(A_START, 0);
    endtask

    task automatic t_div_table();
        wr(A_CTRL, ctl_word(1'b0, 1'b0, 8'h22));
        t_div_one(4'h0, 2);
        t_div_one(4'h1, 4);
        t_div_one(4'h2, 8);
        t_div_one(4'h3, 16);
        t_div_one(4'h8, 32);
        t_div_one(4'h9, 64);
        t_div_one(4'hA, 128);
        t_div_one(4'hB, 1);
        t_div_one(4'h4, 2);   // bit 2 ignored
        t_div_one(4'hF, 1);   // bit 2 ignored
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        int unsigned base, w;
        wr(A_CTRL, ctl_word(1'b1, 1'b0, 8'h9C));
        wr(A_DIV, 32'h0);
        base = pulse_total;
        wr(A_START, 4);
        w = wr_cyc;
        wait_to(w + 8);
        rd(A_NOW, d); chk("R6 at zero", d, 0);
        wait_to(w + 10);
        rd(A_NOW, d); chk("R6 reloaded", d, 4);
        wait_to(w + 30);
        chk("R6 pulse count", pulse_total - base, 3);
        chk("R6 first", pulse_cyc[base % 64], w + 8);
        chk("R6 second", pulse_cyc[(base + 1) % 64], w + 18);
        chk("R6 third", pulse_cyc[(base + 2) % 64], w + 28);
        chk("R9 periodic vector", {24'b0, pulse_vec[(base + 2) % 64]}, 32'h9C);
        wr(A_START, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        int unsigned base, w;
        wr(A_CTRL, ctl_word(1'b1, 1'b1, 8'h11));
        wr(A_DIV, 32'hB);
        base = pulse_total;
        wr(A_START, 3);
        w = wr_cyc;
        wait_to(w + 2);
        rd(A_NOW, d); chk("R7 still counting", d, 1);
        wait_to(w + 4);
        rd(A_NOW, d); chk("R7 reload while masked", d, 3);
        wait_to(w + 30);
        chk("R7 no request", pulse_total - base, 0);
        wr(A_START, 0);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        int unsigned base, w;
        wr(A_CTRL, ctl_word(1'b0, 1'b0, 8'h05));
        wr(A_DIV, 32'hB);
        base = pulse_total;
        wr(A_START, 8);
        w = wr_cyc;
        wait_to(w + 3);
        wr(A_START, 0);
        w = wr_cyc;
        @(negedge clk);
        rd(A_NOW, d); chk("R8 count zero", d, 0);
        wait_to(w + 20);
        rd(A_NOW, d); chk("R8 stays zero", d, 0);
        chk("R8 no request", pulse_total - base, 0);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        int unsigned base, w;
        wr(A_CTRL, ctl_word(1'b0, 1'b0, 8'h77));
        wr(A_DIV, 32'hB);
        base = pulse_total;
        wr(A_START, 10);
        w = wr_cyc;
        wait_to(w + 4);
        wr(A_START, 10);
        w = wr_cyc;
        @(negedge clk);
        rd(A_NOW, d); chk("R11 restarted", d, 10);
        wait_to(w + 20);
        chk("R11 single pulse", pulse_total - base, 1);
        chk("R11 timing", pulse_cyc[base % 64], w + 10);
        wr(A_START, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(A_CTRL, ctl_word(1'b0, 1'b1, 8'h3A));
        wr(A_DIV, 32'h9);
        wr(12'h3F0, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(12'h3F0, d); chk("R10 unmapped reads 0", d, 0);
        rd(A_CTRL, d);  chk("R10 ctrl untouched", d, ctl_word(1'b0, 1'b1, 8'h3A));
        rd(A_DIV, d);   chk("R10 div untouched", d, 32'h9);
        wr(A_CTRL, 32'hFFFF_FFFF);
        wr(A_DIV, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_CTRL, d);  chk("R10 ctrl fields", d, 32'h0003_00FF);
        rd(A_DIV, d);   chk("R10 div field", d, 32'hF);
        wr(A_CTRL, ctl_word(1'b0, 1'b1, 8'h00));
        wr(A_DIV, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_div_table();
        t_periodic();
        t_mask();
        t_zero();
        t_restart();
        t_map();
        chk("R9 no adjacent pulses", dbl_total, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule